// File: doc/BRIEF.md
# Host Parallel Bus Interface with Posted Writes

This block joins a host processor to an internal register file over a strapped parallel bus. Two mode pins choose between four bus types. Three of them multiplex the address and the data on one bus: an 8-bit bus with separate read and write strobes, a 16-bit bus with separate low-byte and high-byte write strobes, and an 8-bit bus that uses an enable strobe plus a read/write direction level. The fourth type carries the address on its own pins. All bus pins are registered once in the block's clock domain, and edges are found from those registered copies.

A few configuration and data-window registers sit in flip-flops and answer at once. Every other location is in a behavioural word memory that needs a fixed number of cycles per access. Writes to that memory are posted: the host is released straight away, and the write completes in the background. A read, or a second write, that arrives while a posted write is still running is held with the wait output until the memory is free. Every memory read also copies the word it returns into the two data-window registers, so the host can fetch both bytes later at fast-register speed.

Top module: `host_bus_if`

## Requirements
- R1: The `mode` pins select the bus type. 0 is the 8-bit multiplexed bus with `rd_n`/`wr_n` strobes. 1 is the 16-bit multiplexed bus. 2 is the 8-bit multiplexed bus where `rd_n` acts as an active-high enable and `wr_n` as a read-high/write-low direction. 3 is the 8-bit bus with separate address pins, where `cs_n` low is the strobe and `wr_n` gives the direction. In every mode, data written at an address reads back unchanged.
- R2: If `mode` is 0 and both `rd_n` and `wr_n` are low in the first cycle after reset release, `serial_sel` goes to 1 and stays there until the next reset. While it is 1 the parallel bus is ignored: `ad_oe` and `ready_oe` stay 0.
- R3: Byte addresses 0x02, 0x04 and 0x05 are fast registers. In 16-bit mode the fast registers are the word at 0x04 and the low byte of the word at 0x02. Fast registers are read and written without asserting the wait.
- R4: A read of any other address asserts the wait (`ready_oe`=1, `ready_n`=0) until the data is on `ad_out` with `ad_oe`=1. The word read is copied into the fast registers: its low byte to 0x04 and its high byte to 0x05.
- R5: A write to a memory location, made while no write is in flight, completes its strobe with no wait. The memory is updated after `MEM_LAT` cycles.
- R6: Only one posted write is in flight at a time. A write whose strobe begins while the previous write is still running is held by the wait until that write finishes, and both writes take effect.
- R7: A memory read that begins while a posted write is still running waits strictly longer than the same read made on an idle memory.
- R8: In 16-bit mode, `wr_n` low writes byte lane [7:0] and `wrh_n` low writes byte lane [15:8]. A lane whose strobe stays high keeps its old contents.
- R9: In the multiplexed modes the address is the value on `ad_in` while `ale` is high, frozen when `ale` falls. Data that is later placed on the same bus does not change the address.
- R10: `int_alt_sel` equals bit 2 of fast register 0x02.
- R11: After reset, `ad_oe`=0, `ready_oe`=0, `ready_n`=1, `serial_sel`=0 and `int_alt_sel`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal memory clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode | input | 2 | Strapped bus-type select |
| cs_n | input | 1 | Chip select, active low |
| ale | input | 1 | Address latch strobe, active high |
| rd_n | input | 1 | Read strobe (active-high enable in mode 2) |
| wr_n | input | 1 | Write strobe, or direction in modes 2 and 3 |
| wrh_n | input | 1 | High-byte write strobe, 16-bit mode |
| addr_in | input | ADDR_W | Separate address pins, mode 3 |
| ad_in | input | 16 | Address/data bus input |
| ad_out | output | 16 | Read data output |
| ad_oe | output | 1 | Data output enable |
| ready_n | output | 1 | Wait level driven while waiting |
| ready_oe | output | 1 | Wait output enable; 0 means released |
| serial_sel | output | 1 | Serial host port selected at reset |
| int_alt_sel | output | 1 | Interrupt routed to the alternate pin |

## Verification
A table of write-then-read pairs exercises the four bus types on memory addresses and on fast addresses. Neighbouring byte addresses within one word are included, so a lane mix-up shows up as wrong data. Directed sequences then contrast wait counts: a fast read against a memory read, an isolated write against one placed directly behind another write, and a read on an idle memory against the same read behind a write. This separates the fast path from the memory path and the free engine from the busy one. Partial-lane writes in 16-bit mode, a data byte equal to a neighbouring address, and the strapped serial case show that lanes are enabled correctly, that the address is frozen at the latch, and that the bus is ignored in serial mode.

// File: rtl/hbi_pkg.sv
package hbi_pkg;

   typedef enum logic [1:0] {
      BUS_MUX8    = 2'd0,
      BUS_MUX16   = 2'd1,
      BUS_MUX8_ES = 2'd2,
      BUS_DIRECT8 = 2'd3
   } bus_mode_e;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_FAST_RD,
      ST_RD_WAIT,
      ST_RD_MEM,
      ST_RD_HOLD,
      ST_WR_WAIT,
      ST_WR_OPEN
   } acc_state_e;

endpackage

// File: rtl/hbi_strobe_decode.sv
module hbi_strobe_decode
   import hbi_pkg::*;
(
   input  bus_mode_e  mode,
   input  logic       cs_n,
   input  logic       rd_n,
   input  logic       wr_n,
   input  logic       wrh_n,
   output logic       act,
   output logic       is_rd,
   output logic [1:0] be
);
   always_comb begin
      act   = 1'b0;
      is_rd = 1'b0;
      be    = 2'b00;
      unique case (mode)
         BUS_MUX8: begin
            act   = !cs_n && (!rd_n || !wr_n);
            is_rd = !rd_n;
         end
         BUS_MUX16: begin
            act   = !cs_n && (!rd_n || !wr_n || !wrh_n);
            is_rd = !rd_n;
            be    = is_rd ? 2'b11 : {!wrh_n, !wr_n};
         end
         BUS_MUX8_ES: begin
            act   = !cs_n && rd_n;
            is_rd = wr_n;
         end
         BUS_DIRECT8: begin
            act   = !cs_n;
            is_rd = wr_n;
         end
         default: ;
      endcase
   end
endmodule

// File: rtl/hbi_addr_hold.sv
module hbi_addr_hold #(
   parameter int ADDR_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ale_s,
   input  logic [ADDR_W-1:0] bus_s,
   output logic [ADDR_W-1:0] addr_q
);
   // follows the bus while the strobe is high, freezes once it falls
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     addr_q <= '0;
      else if (ale_s) addr_q <= bus_s;
   end
endmodule

// File: rtl/hbi_regmem.sv
module hbi_regmem #(
   parameter int WORD_AW = 7,
   parameter int LANES   = 2,
   parameter int LAT     = 4
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 start,
   input  logic                 we,
   input  logic [WORD_AW-1:0]   addr,
   input  logic [8*LANES-1:0]   wdata,
   input  logic [LANES-1:0]     be,
   output logic                 busy,
   output logic                 done,
   output logic [8*LANES-1:0]   rdata
);
   localparam int DW    = 8 * LANES;
   localparam int DEPTH = 1 << WORD_AW;
   localparam int CW    = $clog2(LAT + 1);

   generate
      if (LAT < 1) begin : g_bad_lat
         $error("hbi_regmem: LAT must be at least 1");
      end
   endgenerate

   logic [DW-1:0]      mem [DEPTH];
   logic [CW-1:0]      cnt;
   logic               op_we;
   logic [WORD_AW-1:0] op_addr;
   logic [DW-1:0]      op_data;
   logic [LANES-1:0]   op_be;
   logic               fin;

   assign fin = busy && (cnt == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy    <= 1'b0;
         done    <= 1'b0;
         cnt     <= '0;
         op_we   <= 1'b0;
         op_addr <= '0;
         op_data <= '0;
         op_be   <= '0;
         rdata   <= '0;
      end else begin
         done <= 1'b0;
         if (start) begin
            busy    <= 1'b1;
            cnt     <= CW'(LAT - 1);
            op_we   <= we;
            op_addr <= addr;
            op_data <= wdata;
            op_be   <= be;
         end else if (fin) begin
            busy <= 1'b0;
            done <= 1'b1;
            if (!op_we) rdata <= mem[op_addr];
         end else if (busy) begin
            cnt <= cnt - 1'b1;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (fin && op_we) begin
         for (int b = 0; b < LANES; b++) begin
            if (op_be[b]) mem[op_addr][b*8 +: 8] <= op_data[b*8 +: 8];
         end
      end
   end
endmodule

// File: rtl/host_bus_if.sv
module host_bus_if
   import hbi_pkg::*;
#(
   parameter int ADDR_W  = 8,
   parameter int MEM_LAT = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [1:0]        mode,
   input  logic              cs_n,
   input  logic              ale,
   input  logic              rd_n,
   input  logic              wr_n,
   input  logic              wrh_n,
   input  logic [ADDR_W-1:0] addr_in,
   input  logic [15:0]       ad_in,
   output logic [15:0]       ad_out,
   output logic              ad_oe,
   output logic              ready_n,
   output logic              ready_oe,
   output logic              serial_sel,
   output logic              int_alt_sel
);
   localparam int LANES   = 2;
   localparam int BUS_W   = 8 * LANES;
   localparam int WORD_AW = ADDR_W - 1;

   generate
      if (ADDR_W < 4 || ADDR_W > 12) begin : g_bad_aw
         $error("host_bus_if: ADDR_W must lie in 4..12");
      end
   endgenerate

   bus_mode_e bmode;
   assign bmode = bus_mode_e'(mode);
   logic wide;
   assign wide = (bmode == BUS_MUX16);

   // single-stage sampling of the host pins
   logic              s_cs_n, s_ale, s_rd_n, s_wr_n, s_wrh_n;
   logic [ADDR_W-1:0] s_addr;
   logic [BUS_W-1:0]  s_ad;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         s_cs_n <= 1'b1; s_ale <= 1'b0; s_rd_n <= 1'b1;
         s_wr_n <= 1'b1; s_wrh_n <= 1'b1; s_addr <= '0; s_ad <= '0;
      end else begin
         s_cs_n <= cs_n; s_ale <= ale; s_rd_n <= rd_n;
         s_wr_n <= wr_n; s_wrh_n <= wrh_n; s_addr <= addr_in; s_ad <= ad_in;
      end
   end

   // strap check in the first cycle after reset
   logic started, serial_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         started  <= 1'b0;
         serial_q <= 1'b0;
      end else if (!started) begin
         started  <= 1'b1;
         serial_q <= (bmode == BUS_MUX8) && !rd_n && !wr_n;
      end
   end
   assign serial_sel = serial_q;

   logic       dec_act, dec_rd;
   logic [1:0] dec_be;
   hbi_strobe_decode u_dec (
      .mode(bmode), .cs_n(s_cs_n), .rd_n(s_rd_n), .wr_n(s_wr_n), .wrh_n(s_wrh_n),
      .act(dec_act), .is_rd(dec_rd), .be(dec_be)
   );

   logic [ADDR_W-1:0] lat_addr;
   hbi_addr_hold #(.ADDR_W(ADDR_W)) u_alat (
      .clk(clk), .rst_n(rst_n), .ale_s(s_ale), .bus_s(s_ad[ADDR_W-1:0]), .addr_q(lat_addr)
   );

   logic act, p_act, start, stop;
   assign act   = dec_act && started && !serial_q;
   assign start = act && !p_act;
   assign stop  = !act && p_act;

   function automatic logic fast_hit(input logic [ADDR_W-1:0] a, input logic wd);
      logic [WORD_AW-1:0] w;
      w = a[ADDR_W-1:1];
      return (w == WORD_AW'(2)) || ((w == WORD_AW'(1)) && (wd || !a[0]));
   endfunction

   logic [ADDR_W-1:0] eff_addr, acc_addr;
   logic [1:0]        acc_be;
   logic              start_fast, acc_fast;
   assign eff_addr   = (bmode == BUS_DIRECT8) ? s_addr : lat_addr;
   assign start_fast = fast_hit(eff_addr, wide);
   assign acc_fast   = fast_hit(acc_addr, wide);

   acc_state_e       state;
   logic [BUS_W-1:0] d_hold, rword;
   logic [7:0]       r_cfg, r_lo, r_hi;

   // lane data and enables for the write being committed
   logic [1:0]       wr_be;
   logic [BUS_W-1:0] wr_data;
   logic             commit, cfg_wr;
   assign wr_be   = wide ? acc_be : (acc_addr[0] ? 2'b10 : 2'b01);
   assign wr_data = wide ? d_hold : {d_hold[7:0], d_hold[7:0]};
   assign commit  = (state == ST_WR_OPEN) && stop;
   assign cfg_wr  = commit && acc_fast && (acc_addr[ADDR_W-1:1] == WORD_AW'(1)) && wr_be[0];

   logic               mem_start, mem_busy, mem_done;
   logic [BUS_W-1:0]   mem_rdata;
   logic [WORD_AW-1:0] mem_addr;
   assign mem_start = (state == ST_IDLE && start && dec_rd && !start_fast && !mem_busy)
                   || (state == ST_RD_WAIT && !stop && !mem_busy)
                   || (commit && !acc_fast);
   assign mem_addr  = (state == ST_IDLE) ? eff_addr[ADDR_W-1:1] : acc_addr[ADDR_W-1:1];

   hbi_regmem #(.WORD_AW(WORD_AW), .LANES(LANES), .LAT(MEM_LAT)) u_mem (
      .clk(clk), .rst_n(rst_n), .start(mem_start), .we(state == ST_WR_OPEN),
      .addr(mem_addr), .wdata(wr_data), .be(wr_be),
      .busy(mem_busy), .done(mem_done), .rdata(mem_rdata)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= ST_IDLE;
         p_act    <= 1'b0;
         acc_addr <= '0;
         acc_be   <= '0;
         d_hold   <= '0;
         rword    <= '0;
         r_cfg    <= '0;
         r_lo     <= '0;
         r_hi     <= '0;
      end else begin
         p_act <= act;
         if (act) d_hold <= s_ad;
         unique case (state)
            ST_IDLE: if (start) begin
               acc_addr <= eff_addr;
               acc_be   <= dec_be;
               if (dec_rd) state <= start_fast ? ST_FAST_RD : (mem_busy ? ST_RD_WAIT : ST_RD_MEM);
               else        state <= mem_busy ? ST_WR_WAIT : ST_WR_OPEN;
            end
            ST_FAST_RD, ST_RD_HOLD: if (!act) state <= ST_IDLE;
            ST_RD_WAIT: begin
               if (stop)           state <= ST_IDLE;
               else if (!mem_busy) state <= ST_RD_MEM;
            end
            ST_RD_MEM: begin
               if (mem_done) begin
                  rword <= mem_rdata;
                  r_lo  <= mem_rdata[7:0];
                  r_hi  <= mem_rdata[15:8];
                  state <= act ? ST_RD_HOLD : ST_IDLE;
               end else if (stop) state <= ST_IDLE;
            end
            ST_WR_WAIT: begin
               if (stop)           state <= ST_IDLE;
               else if (!mem_busy) state <= ST_WR_OPEN;
            end
            ST_WR_OPEN: if (stop) begin
               if (acc_fast && acc_addr[ADDR_W-1:1] == WORD_AW'(1)) begin
                  if (wr_be[0]) r_cfg <= wr_data[7:0];
               end else if (acc_fast) begin
                  if (wr_be[0]) r_lo <= wr_data[7:0];
                  if (wr_be[1]) r_hi <= wr_data[15:8];
               end
               state <= ST_IDLE;
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   logic [BUS_W-1:0] fast_word, out_word;
   assign fast_word = (acc_addr[ADDR_W-1:1] == WORD_AW'(1)) ? {8'h00, r_cfg} : {r_hi, r_lo};
   assign out_word  = (state == ST_FAST_RD) ? fast_word : rword;
   assign ad_out    = wide ? out_word
                           : {8'h00, (acc_addr[0] ? out_word[15:8] : out_word[7:0])};
   assign ad_oe     = (state == ST_FAST_RD) || (state == ST_RD_HOLD);

   logic idle_wait;
   assign idle_wait = (state == ST_IDLE) && start && (dec_rd ? !start_fast : mem_busy);
   assign ready_oe  = idle_wait || (state == ST_RD_WAIT) || (state == ST_RD_MEM)
                   || (state == ST_WR_WAIT);
   assign ready_n   = !ready_oe;
   assign int_alt_sel = r_cfg[2];
endmodule

// File: rtl/hbi_checker.sv
module hbi_checker (
   input logic clk,
   input logic rst_n,
   input logic ad_oe,
   input logic ready_oe,
   input logic serial_sel,
   input logic int_alt_sel,
   input logic mem_start,
   input logic mem_busy,
   input logic cfg_wr
);
   // R2: bus stays silent once the serial port is strapped
   a_r2_serial_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      serial_sel |-> (!ad_oe && !ready_oe && !mem_start));

   // R4: data is never driven while the host is being held
   a_r4_no_drive_in_wait: assert property (@(posedge clk) disable iff (!rst_n)
      ready_oe |-> !ad_oe);

   // R6: a new memory operation is only issued to an idle engine
   a_r6_single_in_flight: assert property (@(posedge clk) disable iff (!rst_n)
      mem_start |-> !mem_busy);

   // R5: an issued operation is accepted by the engine
   a_r5_post_accepted: assert property (@(posedge clk) disable iff (!rst_n)
      mem_start |=> mem_busy);

   // R10: routing bit moves only after a write to the configuration byte
   a_r10_route_stable: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(cfg_wr) |-> $stable(int_alt_sel));
endmodule

bind host_bus_if hbi_checker u_chk (
   .clk(clk), .rst_n(rst_n), .ad_oe(ad_oe), .ready_oe(ready_oe),
   .serial_sel(serial_sel), .int_alt_sel(int_alt_sel),
   .mem_start(mem_start), .mem_busy(mem_busy), .cfg_wr(cfg_wr)
);

// File: tb/host_bus_if_tb.sv
module host_bus_if_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [1:0]  mode = 2'd0;
   logic        cs_n = 1'b1, ale = 1'b0, rd_n = 1'b1, wr_n = 1'b1, wrh_n = 1'b1;
   logic [7:0]  addr_in = '0;
   logic [15:0] ad_in = '0;
   logic [15:0] ad_out;
   logic        ad_oe, ready_n, ready_oe, serial_sel, int_alt_sel;

   always #2.5 clk = ~clk;

   host_bus_if u_dut (
      .clk(clk), .rst_n(rst_n), .mode(mode), .cs_n(cs_n), .ale(ale), .rd_n(rd_n),
      .wr_n(wr_n), .wrh_n(wrh_n), .addr_in(addr_in), .ad_in(ad_in), .ad_out(ad_out),
      .ad_oe(ad_oe), .ready_n(ready_n), .ready_oe(ready_oe),
      .serial_sel(serial_sel), .int_alt_sel(int_alt_sel)
   );

   int n_chk = 0, n_fail = 0, cycles = 0;
   logic [15:0] got;
   logic        got_oe;
   int          waits;

   always @(posedge clk) begin
      cycles++;
      if (cycles == 150000) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog actual=%0d expected=<150000 cycles", cycles);
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic set_mode(input logic [1:0] m);
      mode = m;
      rd_n = (m == 2'd2) ? 1'b0 : 1'b1;
      @(negedge clk);
   endtask

   task automatic access(input bit wr, input logic [7:0] a, input logic [15:0] d,
                         input logic [1:0] bsel);
      if (mode != 2'd3) begin
         ad_in = {8'h00, a}; ale = 1'b1;
         @(negedge clk);
         ale = 1'b0;
         @(negedge clk);
      end else addr_in = a;
      ad_in = d;
      case (mode)
         2'd0: begin cs_n = 1'b0; if (wr) wr_n = 1'b0; else rd_n = 1'b0; end
         2'd1: begin
            cs_n = 1'b0;
            if (wr) begin wr_n = !bsel[0]; wrh_n = !bsel[1]; end else rd_n = 1'b0;
         end
         2'd2: begin wr_n = !wr; cs_n = 1'b0; rd_n = 1'b1; end
         default: begin wr_n = !wr; cs_n = 1'b0; end
      endcase
      idle(2);
      waits = 0;
      while (ready_oe) begin waits++; @(negedge clk); end
      got = ad_out; got_oe = ad_oe;
      cs_n = 1'b1; wr_n = 1'b1; wrh_n = 1'b1;
      rd_n = (mode == 2'd2) ? 1'b0 : 1'b1;
      idle(2);
   endtask

   // {mode, addr, data, byte lanes, expected read value}
   localparam int NV = 8;
   localparam logic [43:0] VEC [NV] = '{
      {2'd0, 8'h10, 16'h005A, 2'b01, 16'h005A},
      {2'd0, 8'h11, 16'h00C3, 2'b01, 16'h00C3},
      {2'd2, 8'h12, 16'h0077, 2'b01, 16'h0077},
      {2'd3, 8'h13, 16'h003C, 2'b01, 16'h003C},
      {2'd1, 8'h20, 16'h1234, 2'b11, 16'h1234},
      {2'd1, 8'h22, 16'hBEEF, 2'b11, 16'hBEEF},
      {2'd3, 8'h04, 16'h0099, 2'b01, 16'h0099},
      {2'd2, 8'h05, 16'h0066, 2'b01, 16'h0066}
   };

   initial begin
      int w_alone;
      idle(3);
      rst_n = 1'b1;
      idle(3);
      // R11 reset state
      chk(!ad_oe && !ready_oe && ready_n && !serial_sel && !int_alt_sel, "R11 reset state",
          {ad_oe, ready_oe, ready_n, serial_sel, int_alt_sel}, 5'b00100);

      // R1 table walk over all bus types
      for (int i = 0; i < NV; i++) begin
         set_mode(VEC[i][43:42]);
         access(1'b1, VEC[i][41:34], VEC[i][33:18], VEC[i][17:16]);
         idle(8);
         access(1'b0, VEC[i][41:34], 16'h0000, 2'b11);
         chk(got == VEC[i][15:0] && got_oe, "R1 readback", got, VEC[i][15:0]);
      end
      idle(8);
      // R4: memory read waits and loads the data window
      set_mode(2'd0);
      access(1'b0, 8'h11, 16'h0, 2'b01);
      chk(waits > 0, "R4 read wait", waits, 1);
      chk(got == 16'h00C3, "R4 read data", got, 16'h00C3);
      access(1'b0, 8'h04, 16'h0, 2'b01);
      chk(got == 16'h005A, "R4 window low", got, 16'h005A);
      // R3: fast read has no wait
      chk(waits == 0, "R3 fast no wait", waits, 0);
      access(1'b0, 8'h05, 16'h0, 2'b01);
      chk(got == 16'h00C3, "R4 window high", got, 16'h00C3);

      // R5 / R6: posted write, then one behind it
      set_mode(2'd3);
      idle(10);
      access(1'b1, 8'h30, 16'h0011, 2'b01);
      chk(waits == 0, "R5 posted no wait", waits, 0);
      access(1'b1, 8'h31, 16'h0022, 2'b01);
      chk(waits > 0, "R6 held write wait", waits, 1);
      idle(10);
      access(1'b0, 8'h30, 16'h0, 2'b01);
      chk(got == 16'h0011, "R6 first write kept", got, 16'h0011);
      access(1'b0, 8'h31, 16'h0, 2'b01);
      chk(got == 16'h0022, "R6 second write kept", got, 16'h0022);

      // R7: read behind a write waits longer
      idle(10);
      access(1'b0, 8'h30, 16'h0, 2'b01);
      w_alone = waits;
      access(1'b1, 8'h32, 16'h0044, 2'b01);
      access(1'b0, 8'h30, 16'h0, 2'b01);
      chk(waits > w_alone, "R7 longer wait", waits, w_alone + 1);
      chk(got == 16'h0011, "R7 read data", got, 16'h0011);

      // R8: byte lanes in 16-bit mode
      set_mode(2'd1);
      access(1'b1, 8'h24, 16'h1234, 2'b11);
      access(1'b1, 8'h24, 16'hAB00, 2'b10);
      idle(8);
      access(1'b0, 8'h24, 16'h0, 2'b11);
      chk(got == 16'hAB34, "R8 high lane only", got, 16'hAB34);
      access(1'b1, 8'h24, 16'h00CD, 2'b01);
      idle(8);
      access(1'b0, 8'h24, 16'h0, 2'b11);
      chk(got == 16'hABCD, "R8 low lane only", got, 16'hABCD);

      // R9: data equal to a neighbouring address does not move the address
      set_mode(2'd0);
      access(1'b1, 8'h41, 16'h0000, 2'b01);
      access(1'b1, 8'h40, 16'h0041, 2'b01);
      idle(8);
      access(1'b0, 8'h40, 16'h0, 2'b01);
      chk(got == 16'h0041, "R9 latched target", got, 16'h0041);
      access(1'b0, 8'h41, 16'h0, 2'b01);
      chk(got == 16'h0000, "R9 neighbour untouched", got, 16'h0000);

      // R10: routing bit
      access(1'b1, 8'h02, 16'h0004, 2'b01);
      chk(int_alt_sel == 1'b1, "R10 route set", int_alt_sel, 1);
      access(1'b0, 8'h02, 16'h0, 2'b01);
      chk(got == 16'h0004 && waits == 0, "R3 cfg fast read", got, 16'h0004);
      access(1'b1, 8'h02, 16'h00FB, 2'b01);
      chk(int_alt_sel == 1'b0, "R10 route clear", int_alt_sel, 0);

      // R2: serial strap
      rst_n = 1'b0; mode = 2'd0; rd_n = 1'b0; wr_n = 1'b0;
      idle(3);
      rst_n = 1'b1;
      idle(2);
      rd_n = 1'b1; wr_n = 1'b1;
      idle(2);
      chk(serial_sel == 1'b1, "R2 serial strap", serial_sel, 1);
      access(1'b0, 8'h04, 16'h0, 2'b01);
      chk(!got_oe && waits == 0, "R2 bus ignored", got_oe, 0);
      rst_n = 1'b0;
      idle(3);
      rst_n = 1'b1;
      idle(3);
      chk(!serial_sel && !ad_oe && !ready_oe, "R11 reset again",
          {serial_sel, ad_oe, ready_oe}, 0);

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule